// File: doc/BRIEF.md
# Protected Flash Erase and Program Controller

This block sits between an 8-bit microcontroller register bus and a behavioural byte-wide flash array. Firmware uses it to program single bytes, erase one page, or erase the whole array. Both erase kinds need a short unlock sequence before they start. First the firmware loads a page number or sets a mass-erase arm bit. Then it writes a key byte to the erase command register. A mass erase is also allowed only while the debug port enable input is high. Any other write to the command register starts nothing and drops the arming.

Every operation holds the controller busy for a number of cycles. That count comes from a modelled clock frequency. The external compute engine has its own busy signal. If that signal is seen high at any point while a program operation runs, the byte is left untouched and a sticky collision flag is raised, so firmware can retry. The controller also keeps a sticky flag that records each falling edge of the engine busy signal. This marks the start of an idle gap.

Top module: `flash_guard_ctrl`

## Requirements
- R1: After reset the status register (address 0x00) reads 0x00, the arm register (0x01) reads 0x00, and every array byte reads 0xFF.
- R2: Writing 1 to arm bit 0 of register 0x01 and then 0xAA to the command register 0x03, with dbg_en high, erases the whole array to 0xFF.
- R3: A 0xAA command write while dbg_en is low starts nothing and leaves the array unchanged.
- R4: Writing a page number to register 0x02 and then 0x55 to register 0x03 sets every byte of that page to 0xFF. Bytes in other pages do not change.
- R5: Every command write clears the arm bit and the page-loaded state. A command value other than 0x55 or 0xAA, or a key written without its setup write, starts nothing.
- R6: Writing a data byte to register 0x06 programs the byte at the address held in 0x04 (low) and 0x05 (high). The stored value becomes the old value AND the new data.
- R7: Status bit 0 reads 1 for exactly 42 cycles per program operation and exactly 20000 cycles per erase, at the default 1000 kHz modelled clock.
- R8: While status bit 0 is 1, program and erase requests are rejected and the array is not changed.
- R9: If the synchronised engine busy is high at any point during a program window, the byte is not written. Status bit 1 is then set, or bit 2 if bit 1 is already set. Writing 1 to either bit clears it.
- R10: Status bit 3 is set on each falling edge of eng_busy. It stays set until a 1 is written to it.
- R11: A page-erase key with a page number of NUM_PAGES or more starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data (combinational) |
| dbg_en | input | 1 | Debug port enabled; required for mass erase |
| eng_busy | input | 1 | Compute engine busy, asynchronous |
| fetch_addr | input | ADDR_W | Array read address |
| fetch_data | output | 8 | Array read data |

## Verification
On every cycle, the assertions check four things. Only one commit of any kind fires in a cycle. A mass erase enters its busy state only with dbg_en high. A committed byte never sees engine busy in the last two sampled cycles. A busy falling edge always leaves the sticky flag set. The bench scenarios are needed for the rest: AND-only programming, page isolation, exact busy lengths, rejection while busy, the dual collision flags, and every way an unlock sequence can be broken.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
   localparam logic [7:0] REG_STAT  = 8'h00;
   localparam logic [7:0] REG_ARM   = 8'h01;
   localparam logic [7:0] REG_PAGE  = 8'h02;
   localparam logic [7:0] REG_CMD   = 8'h03;
   localparam logic [7:0] REG_ALO   = 8'h04;
   localparam logic [7:0] REG_AHI   = 8'h05;
   localparam logic [7:0] REG_PDATA = 8'h06;

   localparam logic [7:0] KEY_MASS = 8'hAA;
   localparam logic [7:0] KEY_PAGE = 8'h55;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_PROG   = 2'd1,
      OP_PERASE = 2'd2,
      OP_MERASE = 2'd3
   } op_e;
endpackage

// File: rtl/fgc_busy_sync.sv
module fgc_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eng_busy,
   output logic busy_s,
   output logic busy_fall
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign busy_s = eng_busy;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= eng_busy;
            else chain_q <= {chain_q[STAGES-2:0], eng_busy};
         end
         assign busy_s = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= busy_s;
   end

   assign busy_fall = prev_q & ~busy_s;
endmodule

// File: rtl/fgc_array.sv
module fgc_array #(
   parameter int PAGE_BYTES = 1024,
   parameter int NUM_PAGES  = 2,
   localparam int TOTAL  = PAGE_BYTES * NUM_PAGES,
   localparam int OFF_W  = $clog2(PAGE_BYTES),
   localparam int PG_W   = $clog2(NUM_PAGES),
   localparam int ADDR_W = OFF_W + PG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [7:0]        prog_data,
   input  logic              perase_en,
   input  logic [PG_W-1:0]   perase_page,
   input  logic              merase_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   logic [7:0] mem [TOTAL];

   initial begin
      for (int i = 0; i < TOTAL; i++) mem[i] = 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (merase_en) begin
         for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
      end else if (perase_en) begin
         for (int i = 0; i < PAGE_BYTES; i++)
            mem[{perase_page, OFF_W'(i)}] <= 8'hFF;
      end else if (prog_en) begin
         mem[prog_addr] <= mem[prog_addr] & prog_data;
      end
   end

   assign rd_data = mem[rd_addr];

   // R2: the first and last bytes are blank right after a mass erase commit
   p_mass_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      merase_en |=> (mem[0] == 8'hFF && mem[TOTAL-1] == 8'hFF));
endmodule

// File: rtl/fgc_sequencer.sv
module fgc_sequencer
   import fgc_pkg::*;
#(
   parameter int NUM_PAGES = 2,
   parameter int ADDR_W    = 11,
   parameter int PROG_CYC  = 42,
   parameter int ERASE_CYC = 20000,
   parameter int MASS_CYC  = 20000,
   localparam int PG_W  = $clog2(NUM_PAGES),
   localparam int HI_W  = ADDR_W - 8,
   localparam int MAXC  = (ERASE_CYC > MASS_CYC) ? ERASE_CYC : MASS_CYC,
   localparam int CNT_W = $clog2(MAXC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_wr,
   input  logic [7:0]        sfr_addr,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              dbg_en,
   input  logic              busy_s,
   input  logic              busy_fall,
   output logic              prog_en,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data,
   output logic              perase_en,
   output logic [PG_W-1:0]   perase_page,
   output logic              merase_en
);
   localparam logic [CNT_W-1:0] LD_PROG  = CNT_W'(PROG_CYC - 1);
   localparam logic [CNT_W-1:0] LD_PAGE  = CNT_W'(ERASE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_MASS  = CNT_W'(MASS_CYC - 1);
   localparam logic [6:0]       NPG      = 7'(NUM_PAGES);

   op_e               st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              arm_q, paged_q, seen_q, edge_q;
   logic [1:0]        coll_q;
   logic [5:0]        page_q;
   logic [7:0]        alo_q;
   logic [HI_W-1:0]   ahi_q;
   logic [ADDR_W-1:0] op_addr_q;
   logic [7:0]        op_data_q;
   logic [PG_W-1:0]   op_page_q;

   logic idle, wr_cmd, wr_stat, go_mass, go_page, go_prog, last, coll_hit;

   assign idle    = (st_q == OP_IDLE);
   assign wr_cmd  = sfr_wr && (sfr_addr == REG_CMD);
   assign wr_stat = sfr_wr && (sfr_addr == REG_STAT);
   assign go_mass = wr_cmd && idle && arm_q && dbg_en && (sfr_wdata == KEY_MASS);
   assign go_page = wr_cmd && idle && paged_q && (sfr_wdata == KEY_PAGE)
                    && ({1'b0, page_q} < NPG);
   assign go_prog = sfr_wr && (sfr_addr == REG_PDATA) && idle;
   assign last    = !idle && (cnt_q == '0);
   assign coll_hit = last && (st_q == OP_PROG) && (seen_q || busy_s);

   assign prog_en     = last && (st_q == OP_PROG) && !seen_q && !busy_s;
   assign perase_en   = last && (st_q == OP_PERASE);
   assign merase_en   = last && (st_q == OP_MERASE);
   assign prog_addr   = op_addr_q;
   assign prog_data   = op_data_q;
   assign perase_page = op_page_q;

   // setup registers and unlock state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         paged_q <= 1'b0;
         page_q  <= '0;
         alo_q   <= '0;
         ahi_q   <= '0;
      end else if (sfr_wr) begin
         case (sfr_addr)
            REG_ARM:  arm_q <= sfr_wdata[0];
            REG_PAGE: begin page_q <= sfr_wdata[5:0]; paged_q <= 1'b1; end
            REG_CMD:  begin arm_q <= 1'b0; paged_q <= 1'b0; end
            REG_ALO:  alo_q <= sfr_wdata;
            REG_AHI:  ahi_q <= sfr_wdata[HI_W-1:0];
            default:  ;
         endcase
      end
   end

   // operation timer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= OP_IDLE;
         cnt_q     <= '0;
         seen_q    <= 1'b0;
         op_addr_q <= '0;
         op_data_q <= '0;
         op_page_q <= '0;
      end else if (idle) begin
         if (go_prog) begin
            st_q      <= OP_PROG;
            cnt_q     <= LD_PROG;
            seen_q    <= busy_s;
            op_addr_q <= {ahi_q, alo_q};
            op_data_q <= sfr_wdata;
         end else if (go_page) begin
            st_q      <= OP_PERASE;
            cnt_q     <= LD_PAGE;
            op_page_q <= page_q[PG_W-1:0];
         end else if (go_mass) begin
            st_q  <= OP_MERASE;
            cnt_q <= LD_MASS;
         end
      end else if (last) begin
         st_q   <= OP_IDLE;
         seen_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
         seen_q <= seen_q | busy_s;
      end
   end

   // sticky flags, write one to clear, set wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coll_q <= '0;
         edge_q <= 1'b0;
      end else begin
         logic [1:0] c;
         c = coll_q;
         if (wr_stat) c = c & ~sfr_wdata[2:1];
         if (coll_hit) begin
            if (!coll_q[0]) c[0] = 1'b1;
            else            c[1] = 1'b1;
         end
         coll_q <= c;
         if (busy_fall)                    edge_q <= 1'b1;
         else if (wr_stat && sfr_wdata[3]) edge_q <= 1'b0;
      end
   end

   always_comb begin
      case (sfr_addr)
         REG_STAT: sfr_rdata = {4'b0, edge_q, coll_q, !idle};
         REG_ARM:  sfr_rdata = {7'b0, arm_q};
         REG_PAGE: sfr_rdata = {2'b0, page_q};
         REG_ALO:  sfr_rdata = alo_q;
         REG_AHI:  sfr_rdata = 8'(ahi_q);
         default:  sfr_rdata = 8'h00;
      endcase
   end

   // R5: at most one array action per cycle
   p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_en, perase_en, merase_en}));
   // R3: a mass erase only begins with the debug port enabled
   p_mass_needs_dbg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OP_MERASE && $past(st_q) == OP_IDLE) |-> $past(dbg_en));
   // R9: a committed byte never coincides with engine busy
   p_commit_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      prog_en |-> (!busy_s && !$past(busy_s)));
   // R8: an operation in flight keeps its kind until the timer expires
   p_hold_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && cnt_q != '0) |=> (st_q == $past(st_q)));
   // R10: a busy falling edge always leaves the edge flag set
   p_edge_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_fall |=> edge_q);
endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl #(
   parameter int CLK_KHZ     = 1000,
   parameter int PROG_NS     = 42000,
   parameter int PERASE_US   = 20000,
   parameter int MERASE_US   = 20000,
   parameter int PAGE_BYTES  = 1024,
   parameter int NUM_PAGES   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W    = $clog2(PAGE_BYTES) + $clog2(NUM_PAGES),
   localparam int PROG_CYC  = (CLK_KHZ * PROG_NS + 999999) / 1000000,
   localparam int ERASE_CYC = (CLK_KHZ * PERASE_US + 999) / 1000,
   localparam int MASS_CYC  = (CLK_KHZ * MERASE_US + 999) / 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_wr,
   input  logic [7:0]        sfr_addr,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              dbg_en,
   input  logic              eng_busy,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [7:0]        fetch_data
);
   localparam int PG_W = $clog2(NUM_PAGES);

   if (NUM_PAGES < 2 || NUM_PAGES > 64 || (NUM_PAGES & (NUM_PAGES - 1)) != 0)
   begin : g_bad_pages
      $error("NUM_PAGES must be a power of two from 2 to 64");
   end
   if (PAGE_BYTES < 256 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0)
   begin : g_bad_page_size
      $error("PAGE_BYTES must be a power of two of at least 256");
   end
   if (PROG_CYC < 2 || ERASE_CYC < 2 || MASS_CYC < 2) begin : g_bad_timing
      $error("operation times must span at least two cycles");
   end

   logic              busy_s, busy_fall;
   logic              prog_en, perase_en, merase_en;
   logic [ADDR_W-1:0] prog_addr;
   logic [7:0]        prog_data;
   logic [PG_W-1:0]   perase_page;

   fgc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
      .busy_s(busy_s), .busy_fall(busy_fall)
   );

   fgc_sequencer #(
      .NUM_PAGES(NUM_PAGES), .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC),
      .ERASE_CYC(ERASE_CYC), .MASS_CYC(MASS_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .dbg_en(dbg_en),
      .busy_s(busy_s), .busy_fall(busy_fall),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .perase_en(perase_en), .perase_page(perase_page), .merase_en(merase_en)
   );

   fgc_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
      .perase_en(perase_en), .perase_page(perase_page), .merase_en(merase_en),
      .rd_addr(fetch_addr), .rd_data(fetch_data)
   );
endmodule

// File: tb/flash_guard_ctrl_tb.sv
module flash_guard_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        dbg_en = 1'b1;
   logic        eng_busy = 1'b0;
   logic [10:0] fetch_addr = '0;
   logic [7:0]  fetch_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam int PROG_LEN  = 42;
   localparam int ERASE_LEN = 20000;

   // {address, data written, expected byte afterwards}
   localparam logic [26:0] VEC [8] = '{
      {11'h005, 8'hA5, 8'hA5},
      {11'h005, 8'h0F, 8'h05},
      {11'h400, 8'h3C, 8'h3C},
      {11'h7FF, 8'h00, 8'h00},
      {11'h005, 8'hFF, 8'h05},
      {11'h400, 8'hF0, 8'h30},
      {11'h001, 8'h7E, 8'h7E},
      {11'h3FF, 8'h81, 8'h81}
   };

   always #4 clk = ~clk;

   flash_guard_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .dbg_en(dbg_en),
      .eng_busy(eng_busy), .fetch_addr(fetch_addr), .fetch_data(fetch_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      sfr_addr = a;
      #1 d = sfr_rdata;
   endtask

   task automatic peek(input logic [10:0] a, output logic [7:0] d);
      fetch_addr = a;
      #1 d = fetch_data;
   endtask

   task automatic busy_len(output int n);
      logic [7:0] s;
      n = 0;
      rd(8'h00, s);
      while (s[0] && n < 100000) begin
         n++;
         @(negedge clk);
         rd(8'h00, s);
      end
   endtask

   task automatic prog(input logic [10:0] a, input logic [7:0] d);
      wr(8'h04, a[7:0]);
      wr(8'h05, {5'b0, a[10:8]});
      wr(8'h06, d);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, v); chk("R1 status", v, 8'h00);
      rd(8'h01, v); chk("R1 arm", v, 8'h00);
      peek(11'h000, v); chk("R1 first byte", v, 8'hFF);
      peek(11'h7FF, v); chk("R1 last byte", v, 8'hFF);

      // R6 table of program vectors; R7 on each length
      for (int i = 0; i < 8; i++) begin
         prog(VEC[i][26:16], VEC[i][15:8]);
         busy_len(n);
         chk("R7 program busy length", n, PROG_LEN);
         peek(VEC[i][26:16], v);
         chk("R6 programmed byte", v, VEC[i][7:0]);
      end

      // R8 requests during a program are rejected
      prog(11'h00A, 8'h00);
      wr(8'h04, 8'h0B);
      wr(8'h06, 8'h00);
      wr(8'h02, 8'h00);
      wr(8'h03, 8'h55);
      busy_len(n);
      peek(11'h00A, v); chk("R8 first program lands", v, 8'h00);
      peek(11'h00B, v); chk("R8 second program rejected", v, 8'hFF);

      // R4 page erase of page 0
      wr(8'h02, 8'h00);
      wr(8'h03, 8'h55);
      busy_len(n); chk("R7 page erase length", n, ERASE_LEN);
      peek(11'h005, v); chk("R4 page0 byte 005", v, 8'hFF);
      peek(11'h00A, v); chk("R4 page0 byte 00A", v, 8'hFF);
      peek(11'h3FF, v); chk("R4 page0 byte 3FF", v, 8'hFF);
      peek(11'h400, v); chk("R4 page1 kept 400", v, 8'h30);
      peek(11'h7FF, v); chk("R4 page1 kept 7FF", v, 8'h00);

      // R11 page out of range
      wr(8'h02, 8'h03);
      wr(8'h03, 8'h55);
      rd(8'h00, v); chk("R11 no busy", v[0], 1'b0);
      peek(11'h400, v); chk("R11 array kept", v, 8'h30);

      // R5 broken sequences
      wr(8'h01, 8'h01);
      rd(8'h01, v); chk("R5 arm set", v, 8'h01);
      wr(8'h03, 8'h12);
      rd(8'h01, v); chk("R5 arm cleared by bad key", v, 8'h00);
      wr(8'h03, 8'hAA);
      rd(8'h00, v); chk("R5 unarmed mass key idle", v[0], 1'b0);
      wr(8'h03, 8'h55);
      rd(8'h00, v); chk("R5 page key without page idle", v[0], 1'b0);
      peek(11'h7FF, v); chk("R5 array kept", v, 8'h00);

      // R3 mass erase without debug enable
      dbg_en = 1'b0;
      wr(8'h01, 8'h01);
      wr(8'h03, 8'hAA);
      rd(8'h00, v); chk("R3 no busy", v[0], 1'b0);
      peek(11'h7FF, v); chk("R3 array kept", v, 8'h00);
      rd(8'h01, v); chk("R5 arm cleared after key", v, 8'h00);

      // R2 mass erase
      dbg_en = 1'b1;
      wr(8'h01, 8'h01);
      wr(8'h03, 8'hAA);
      busy_len(n); chk("R7 mass erase length", n, ERASE_LEN);
      peek(11'h400, v); chk("R2 byte 400 blank", v, 8'hFF);
      peek(11'h7FF, v); chk("R2 byte 7FF blank", v, 8'hFF);

      // R9 collisions
      wr(8'h00, 8'h0E);
      prog(11'h020, 8'h00);
      @(negedge clk); eng_busy = 1'b1;
      repeat (6) @(negedge clk);
      eng_busy = 1'b0;
      busy_len(n);
      peek(11'h020, v); chk("R9 byte untouched", v, 8'hFF);
      rd(8'h00, v); chk("R9 first flag", v[2:1], 2'b01);
      prog(11'h020, 8'h00);
      @(negedge clk); eng_busy = 1'b1;
      repeat (6) @(negedge clk);
      eng_busy = 1'b0;
      busy_len(n);
      rd(8'h00, v); chk("R9 second flag", v[2:1], 2'b11);
      wr(8'h00, 8'h06);
      rd(8'h00, v); chk("R9 flags cleared", v[2:1], 2'b00);
      prog(11'h020, 8'h00);
      busy_len(n);
      peek(11'h020, v); chk("R9 retry lands", v, 8'h00);

      // R10 busy falling edge flag
      wr(8'h00, 8'h08);
      rd(8'h00, v); chk("R10 flag cleared", v[3], 1'b0);
      eng_busy = 1'b1;
      repeat (4) @(negedge clk);
      eng_busy = 1'b0;
      repeat (5) @(negedge clk);
      rd(8'h00, v); chk("R10 flag set", v[3], 1'b1);
      repeat (20) @(negedge clk);
      rd(8'h00, v); chk("R10 flag sticky", v[3], 1'b1);
      wr(8'h00, 8'h08);
      rd(8'h00, v); chk("R10 flag cleared by write", v[3], 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule